// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the register file of a processor that hands every procedure its own window of registers. The windows sit in a circular buffer, and each window shares eight registers with its neighbour. The registers a caller fills as outgoing arguments are the same storage the callee sees as its incoming registers, so arguments pass without any copying. A bank of seven global registers, plus a hard-wired zero, is visible from every window. All 32 logical register numbers share one numbering, so an instruction always carries a 5-bit register field, whatever the current window is.

The core has two combinational read ports and one write port, all addressed by logical register number. A call strobe moves the current-window pointer down by one window and a return strobe moves it back up. A live-window counter tracks how many procedures own windows. When a call would overrun the oldest live window, the block raises an overflow pulse instead of moving. When a return would leave no live window, it raises an underflow pulse. Spilling windows to memory and filling them back is left to whatever services these pulses.

Logical numbers 0-7 select globals, 8-15 outgoing, 16-23 local and 24-31 incoming. For a windowed register r, the physical slot is (cwp*16 + r - 8) modulo (NWIN*16). A call therefore makes caller register 8+k the callee's register 24+k.

Top module: `regwin_file`

## Requirements
- R1: After reset, `cwp_o` is 0, one window is live, and `overflow_o` and `underflow_o` are 0.
- R2: Logical register 0 always reads as zero on both ports, and writes to it have no effect.
- R3: Logical registers 1-7 are global: a value written there reads back unchanged from any window.
- R4: An accepted call sets `cwp_o` to `cwp_o - 1` modulo NWIN, so 0 wraps to NWIN-1. An accepted return sets it to `cwp_o + 1` modulo NWIN. The change appears at the next clock edge.
- R5: After a call, the callee reads the caller's register 8+k (k = 0..7) as its register 24+k. After a return, the caller reads what the callee wrote to 24+k at its own 8+k.
- R6: Local registers 16-23 belong to their window alone: a write in the callee's window leaves the caller's locals unchanged.
- R7: At most NWIN windows are live (NWIN-1 nested calls from reset). A call when NWIN windows are live pulses `overflow_o` for one cycle at the next edge and leaves `cwp_o` and the live count unchanged.
- R8: A return with one live window pulses `underflow_o` for one cycle at the next edge and leaves `cwp_o` unchanged.
- R9: A read of the register being written in the same cycle returns the new write data (write-first). From the next cycle on, the stored value is returned.
- R10: Call and return asserted together have no effect: `cwp_o` holds and neither flag rises.
- R11: The two read ports work independently: in one cycle they return the values of two different registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 5 | Logical register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_addr | input | 5 | Logical register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | XLEN | Write data |
| call_i | input | 1 | Call strobe: enter a new window |
| ret_i | input | 1 | Return strobe: go back to the caller's window |
| cwp_o | output | WIN_BITS | Current window pointer |
| overflow_o | output | 1 | One-cycle pulse: call refused, windows full |
| underflow_o | output | 1 | One-cycle pulse: return refused, no caller window |

## Verification
Read data is combinational, so it is due in the same cycle its address is presented. A written value is due from the cycle after the write edge, or in the write cycle itself when read through the bypass. The window pointer and both flags are registered and change at the first edge after the strobe. The bench drives every input just after a rising edge and queues the expected values. A monitor compares them at the following falling edge, which is the first point where every result for that cycle is settled.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int XLEN     = 32,
  parameter int WIN_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          rd_a_addr,
  output logic [XLEN-1:0]     rd_a_data,
  input  logic [4:0]          rd_b_addr,
  output logic [XLEN-1:0]     rd_b_data,
  input  logic                wr_en,
  input  logic [4:0]          wr_addr,
  input  logic [XLEN-1:0]     wr_data,
  input  logic                call_i,
  input  logic                ret_i,
  output logic [WIN_BITS-1:0] cwp_o,
  output logic                overflow_o,
  output logic                underflow_o
);
  localparam int NWIN  = 1 << WIN_BITS;
  localparam int PHYS  = NWIN * 16;
  localparam int PBITS = WIN_BITS + 4;
  localparam logic [WIN_BITS:0]   MAXLIVE = (WIN_BITS+1)'(NWIN);
  localparam logic [WIN_BITS:0]   ONELIVE = (WIN_BITS+1)'(1);
  localparam logic [WIN_BITS-1:0] STEP    = WIN_BITS'(1);

  logic [XLEN-1:0] glob [8];
  logic [XLEN-1:0] win  [PHYS];
  logic [WIN_BITS:0] live_cnt;

  function automatic logic [PBITS-1:0] slot(input logic [WIN_BITS-1:0] w, input logic [4:0] r);
    return {w, 4'b0000} + PBITS'(r - 5'd8);
  endfunction

  wire full    = (live_cnt == MAXLIVE);
  wire empty   = (live_cnt == ONELIVE);
  wire call_go = call_i && !ret_i && !full;
  wire ret_go  = ret_i && !call_i && !empty;
  wire wr_go   = wr_en && (wr_addr != 5'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_o       <= '0;
      live_cnt    <= ONELIVE;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      overflow_o  <= call_i && !ret_i && full;
      underflow_o <= ret_i && !call_i && empty;
      if (call_go) begin
        cwp_o    <= cwp_o - STEP;
        live_cnt <= live_cnt + ONELIVE;
      end else if (ret_go) begin
        cwp_o    <= cwp_o + STEP;
        live_cnt <= live_cnt - ONELIVE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      if (wr_addr < 5'd8) glob[wr_addr[2:0]] <= wr_data;
      else                win[slot(cwp_o, wr_addr)] <= wr_data;
    end
  end

  function automatic logic [XLEN-1:0] fetch(input logic [4:0] a);
    if (a == 5'd0)             return '0;
    if (wr_go && wr_addr == a) return wr_data;
    if (a < 5'd8)              return glob[a[2:0]];
    return win[slot(cwp_o, a)];
  endfunction

  always_comb rd_a_data = fetch(rd_a_addr);
  always_comb rd_b_data = fetch(rd_b_addr);

  p_call_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    call_go |=> cwp_o == $past(cwp_o) - STEP);

  p_ret_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> cwp_o == $past(cwp_o) + STEP);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> cwp_o == $past(cwp_o));

  p_live_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt >= ONELIVE && live_cnt <= MAXLIVE);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> cwp_o == $past(cwp_o));

  p_both_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(cwp_o) && !overflow_o && !underflow_o);

  p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == 5'd0) |-> rd_b_data == '0);
endmodule

// File: tb/regwin_file_test.sv
module regwin_file_test;
  localparam int XLEN = 32;
  localparam int WB   = 3;
  localparam int NW   = 1 << WB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [XLEN-1:0] rd_a_data, rd_b_data;
  logic [WB-1:0] cwp;
  logic ovf, unf;

  regwin_file #(.XLEN(XLEN), .WIN_BITS(WB)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cwp), .overflow_o(ovf), .underflow_o(unf));

  always #5 clk = ~clk;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0: act = rd_a_data;
        1: act = rd_b_data;
        2: act = 32'(cwp);
        3: act = 32'(ovf);
        default: act = 32'(unf);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] a, input logic [31:0] e, input string tag);
    rd_a_addr = a;
    expect_item(0, e, tag);
    cyc();
  endtask

  task automatic rd_b(input logic [4:0] a, input logic [31:0] e, input string tag);
    rd_b_addr = a;
    expect_item(1, e, tag);
    cyc();
  endtask

  task automatic strobe(input logic c, input logic r, input int ecwp,
                        input logic eo, input logic eu, input string tag);
    call_i = c; ret_i = r;
    cyc();
    call_i = 1'b0; ret_i = 1'b0;
    expect_item(2, 32'(ecwp), tag);
    expect_item(3, 32'(eo), tag);
    expect_item(4, 32'(eu), tag);
    cyc();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_item(2, 0, "R1 cwp after reset");
    expect_item(3, 0, "R1 overflow after reset");
    expect_item(4, 0, "R1 underflow after reset");
    cyc();

    wr(5'd0, 32'hDEAD_BEEF);
    rd_a(5'd0, 32'h0, "R2 zero reg port A");
    rd_b(5'd0, 32'h0, "R2 zero reg port B");

    wr(5'd5, 32'h6060_0005);
    wr(5'd16, 32'h1111_0000);
    wr(5'd10, 32'hA0A0_0002);

    strobe(1'b1, 1'b0, 7, 1'b0, 1'b0, "R4 call wraps 0 to 7");
    rd_a(5'd26, 32'hA0A0_0002, "R5 caller out 10 is callee in 26");
    rd_b(5'd5, 32'h6060_0005, "R3 global seen from window 7");
    wr(5'd16, 32'h2222_0007);
    wr(5'd25, 32'hBEEF_0001);
    rd_a(5'd16, 32'h2222_0007, "R6 callee local");

    strobe(1'b0, 1'b1, 0, 1'b0, 1'b0, "R4 return to window 0");
    rd_a(5'd16, 32'h1111_0000, "R6 caller local intact");
    rd_b(5'd9, 32'hBEEF_0001, "R5 callee in 25 is caller out 9");

    strobe(1'b0, 1'b1, 0, 1'b0, 1'b1, "R8 return with one live window");
    strobe(1'b0, 1'b0, 0, 1'b0, 1'b0, "R8 underflow is one cycle");

    for (int i = 1; i < NW; i++)
      strobe(1'b1, 1'b0, (NW - i) % NW, 1'b0, 1'b0, "R4 nested call");
    strobe(1'b1, 1'b0, 1, 1'b1, 1'b0, "R7 call with all windows live");
    strobe(1'b1, 1'b1, 1, 1'b0, 1'b0, "R10 call and return together");
    rd_a(5'd5, 32'h6060_0005, "R3 global seen from window 1");

    wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h5A5A_0014;
    rd_a_addr = 5'd20;
    expect_item(0, 32'h5A5A_0014, "R9 write-first bypass");
    cyc();
    wr_en = 1'b0;
    rd_b(5'd20, 32'h5A5A_0014, "R9 stored after write");

    rd_a_addr = 5'd5; rd_b_addr = 5'd20;
    expect_item(0, 32'h6060_0005, "R11 port A independent");
    expect_item(1, 32'h5A5A_0014, "R11 port B independent");
    cyc();

    for (int j = 1; j < NW; j++)
      strobe(1'b0, 1'b1, (1 + j) % NW, 1'b0, 1'b0, "R4 unwinding return");
    rd_a(5'd16, 32'h1111_0000, "R6 window 0 local after unwind");
    strobe(1'b0, 1'b1, 0, 1'b0, 1'b1, "R8 underflow after unwind");

    cyc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule